// File: doc/BRIEF.md
# Iterative AES Forward-Cipher Datapath

This block encrypts one 128-bit block per operation with the AES forward cipher. It supports two key sizes: 128-bit keys (10 rounds) and 256-bit keys (14 rounds). The block does not expand the key itself. It drives a 4-bit round index to an outside key store and takes back, in the same cycle, the 128-bit round key held at that index. Byte substitution is also done outside the block. The block presents one 32-bit word of its state to a shared combinational S-box and writes back the substituted word that returns.

A one-cycle start pulse does three things: it captures the plaintext block, it captures the key-size selector and it clears the ready flag. The block then performs the initial key addition. After that it runs each round as four substitution cycles, one per state word, followed by one update cycle. Every round except the last applies row rotation, column mixing and key addition. The last round leaves out the column mixing. When the last round is done, ready rises with the ciphertext on the output. Ready stays high, and the output stays unchanged, until the next start.

Top module: `aes_enc_core`

## Requirements
- R1: After the active-low asynchronous reset, `ready` is 1, `round_idx` is 0 and `block_out` is all zeros.
- R2: With `long_key`=0, the output after completion is the AES-128 encryption of the captured block, using round keys 0..10. Key 2b7e151628aed2a6abf7158809cf4f3c and block 6bc1bee22e409f96e93d7e117393172a give 3ad77bb40d7a3660a89ecaf32466ef97.
- R3: With `long_key`=1, the output is the AES-256 encryption, using round keys 0..14. Key 603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4 and the same block give f3eed1bdb5d2a03c064b5a7e3db181f8.
- R4: During an operation, `round_idx` never exceeds the last round of the selected key size, and it reaches that value (10 or 14).
- R5: If start is sampled at clock edge E, ready rises at edge E+1+5*Nr: 51 cycles for 128-bit keys and 71 cycles for 256-bit keys.
- R6: Ready falls at the edge that samples start. When idle, ready stays high and `block_out` stays unchanged while start is low.
- R7: A start pulse while an operation is running (ready low) is ignored. The running operation finishes with its own result and latency, and no extra completion follows.
- R8: In each substitution phase, `sbox_out` presents the state words in order, one per cycle: word 0 (bits 127:96) first, then word 1 (95:64), word 2 (63:32) and word 3 (31:0). In round 1 these words are the block XOR round key 0.
- R9: `long_key` is sampled only with an accepted start. Changing it during an operation does not change the result or the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted only when idle |
| long_key | input | 1 | Key size: 0 = 128-bit, 1 = 256-bit |
| round_idx | output | 4 | Index of the round key requested from the key store |
| round_key | input | 128 | Round key for `round_idx`, returned combinationally |
| sbox_out | output | 32 | State word sent to the external S-box |
| sbox_in | input | 32 | Substituted word returned combinationally |
| block_in | input | 128 | Plaintext block, captured at start |
| block_out | output | 128 | Cipher state; the ciphertext once ready is high |
| ready | output | 1 | High when idle and the result is valid |

## Verification
The hardest case to reach from the ports is a running operation whose inputs are disturbed: a second start pulse with a different block, or a key-size change, arriving mid-operation. The stimulus sends these pulses a few cycles into an operation. The scoreboard then holds the original expected ciphertext and completion cycle, and any extra completion with an empty queue counts as a failure. The order of S-box requests is observed directly on `sbox_out` right after the initial key addition, against the block XOR round key 0 that the bench computes itself.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BLK_W   = 128;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = BLK_W / WORD_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SUB,
    ST_MIX,
    ST_LAST
  } ctl_state_e;

  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_KEY,
    UPD_FULL,
    UPD_LAST
  } upd_kind_e;

  // multiply a field element by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    gf_dbl = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // column mixing of one 32-bit column, row 0 in the top byte
  function automatic logic [31:0] mix_one(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    a0 = w[31:24];
    a1 = w[23:16];
    a2 = w[15:8];
    a3 = w[7:0];
    mix_one = {gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3,
               a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3,
               a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3,
               gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3)};
  endfunction

  // row r of column c takes row r of column (c+r) mod 4
  function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    o = '0;
    for (int c = 0; c < N_WORDS; c++) begin
      for (int r = 0; r < 4; r++) begin
        o[BLK_W-1-WORD_W*c-8*r -: 8] =
          s[BLK_W-1-WORD_W*((c+r)%N_WORDS)-8*r -: 8];
      end
    end
    shift_rows = o;
  endfunction

  function automatic logic [BLK_W-1:0] mix_cols(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < N_WORDS; c++) begin
      o[BLK_W-1-WORD_W*c -: WORD_W] = mix_one(s[BLK_W-1-WORD_W*c -: WORD_W]);
    end
    mix_cols = o;
  endfunction

endpackage

// File: rtl/aes_enc_seq.sv
module aes_enc_seq
  import aes_enc_pkg::*;
#(
  parameter int R_SHORT = 10,
  parameter int R_LONG  = 14,
  parameter int RW      = 4,
  parameter int WCW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           long_key,
  output logic [RW-1:0]  round_idx,
  output logic [WCW-1:0] word_idx,
  output upd_kind_e      upd,
  output logic           sub_en,
  output logic           load,
  output logic           ready
);

  localparam logic [RW-1:0]  NR_S     = RW'(R_SHORT);
  localparam logic [RW-1:0]  NR_L     = RW'(R_LONG);
  localparam logic [WCW-1:0] LAST_WRD = {WCW{1'b1}};

  ctl_state_e     st_q;
  logic [RW-1:0]  round_q;
  logic [WCW-1:0] word_q;
  logic           rdy_q;
  logic           klen_q;

  // named internal events
  logic           start_ok;
  logic           last_word;
  logic           last_round;
  logic [RW-1:0]  nr_sel;

  assign nr_sel     = klen_q ? NR_L : NR_S;
  assign start_ok   = (st_q == ST_IDLE) && start;
  assign last_word  = (word_q == LAST_WRD);
  assign last_round = (round_q == nr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      round_q <= '0;
      word_q  <= '0;
      rdy_q   <= 1'b1;
      klen_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_ok) begin
            klen_q  <= long_key;
            round_q <= '0;
            word_q  <= '0;
            rdy_q   <= 1'b0;
            st_q    <= ST_INIT;
          end
        end
        ST_INIT: begin
          round_q <= RW'(1);
          word_q  <= '0;
          st_q    <= ST_SUB;
        end
        ST_SUB: begin
          word_q <= word_q + 1'b1;
          if (last_word) st_q <= last_round ? ST_LAST : ST_MIX;
        end
        ST_MIX: begin
          round_q <= round_q + 1'b1;
          st_q    <= ST_SUB;
        end
        ST_LAST: begin
          rdy_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_INIT: upd = UPD_KEY;
      ST_MIX:  upd = UPD_FULL;
      ST_LAST: upd = UPD_LAST;
      default: upd = UPD_NONE;
    endcase
  end

  assign round_idx = round_q;
  assign word_idx  = word_q;
  assign sub_en    = (st_q == ST_SUB);
  assign load      = start_ok;
  assign ready     = rdy_q;

  // R4: the round index stays within the selected key schedule
  a_r4_round_limit: assert property (@(posedge clk) disable iff (!rst_n)
    round_q <= nr_sel);

  // R5: each full-round update advances the round index by one
  a_r5_round_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MIX) |=> (round_q == RW'($past(round_q) + 1'b1)));

  // R6: ready falls on an accepted start and holds otherwise while idle
  a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready);
  a_r6_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

  // R7/R9: while busy the captured key size cannot change
  a_r9_klen_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(klen_q));

  // R8: substitution walks the words in ascending order
  a_r8_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en && !last_word) |=> (sub_en && word_q == WCW'($past(word_q) + 1'b1)));

endmodule

// File: rtl/aes_enc_subst.sv
module aes_enc_subst #(
  parameter int WORDS = 4,
  parameter int WW    = 32,
  parameter int WCW   = 2
) (
  input  logic [WORDS*WW-1:0] state,
  input  logic [WCW-1:0]      sel,
  input  logic [WW-1:0]       sbox_in,
  output logic [WW-1:0]       sbox_out,
  output logic [WORDS*WW-1:0] state_sub
);

  logic [WW-1:0] words [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    // word 0 sits in the most significant slot
    assign words[i] = state[(WORDS-1-i)*WW +: WW];
    assign state_sub[(WORDS-1-i)*WW +: WW] =
      (sel == WCW'(i)) ? sbox_in : words[i];
  end

  assign sbox_out = words[sel];

endmodule

// File: rtl/aes_enc_round.sv
module aes_enc_round
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] state,
  input  logic [BLK_W-1:0] rkey,
  input  upd_kind_e        kind,
  output logic [BLK_W-1:0] next_state
);

  logic [BLK_W-1:0] shifted;
  logic [BLK_W-1:0] mixed;

  assign shifted = shift_rows(state);
  assign mixed   = mix_cols(shifted);

  always_comb begin
    case (kind)
      UPD_KEY:  next_state = state ^ rkey;
      UPD_FULL: next_state = mixed ^ rkey;
      UPD_LAST: next_state = shifted ^ rkey;
      default:  next_state = state;
    endcase
  end

endmodule

// File: rtl/aes_enc_core.sv
module aes_enc_core
  import aes_enc_pkg::*;
#(
  parameter int ROUNDS_128 = 10,
  parameter int ROUNDS_256 = 14,
  localparam int RIDX_W    = $clog2(ROUNDS_256 + 1),
  localparam int WSEL_W    = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_key,
  output logic [RIDX_W-1:0] round_idx,
  input  logic [BLK_W-1:0]  round_key,
  output logic [WORD_W-1:0] sbox_out,
  input  logic [WORD_W-1:0] sbox_in,
  input  logic [BLK_W-1:0]  block_in,
  output logic [BLK_W-1:0]  block_out,
  output logic              ready
);

  logic [BLK_W-1:0]  state_q;
  logic [BLK_W-1:0]  state_sub;
  logic [BLK_W-1:0]  state_upd;
  logic [WSEL_W-1:0] word_idx;
  upd_kind_e         upd;
  logic              sub_en;
  logic              load;

  aes_enc_seq #(
    .R_SHORT (ROUNDS_128),
    .R_LONG  (ROUNDS_256),
    .RW      (RIDX_W),
    .WCW     (WSEL_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .long_key  (long_key),
    .round_idx (round_idx),
    .word_idx  (word_idx),
    .upd       (upd),
    .sub_en    (sub_en),
    .load      (load),
    .ready     (ready)
  );

  aes_enc_subst #(
    .WORDS (N_WORDS),
    .WW    (WORD_W),
    .WCW   (WSEL_W)
  ) u_subst (
    .state     (state_q),
    .sel       (word_idx),
    .sbox_in   (sbox_in),
    .sbox_out  (sbox_out),
    .state_sub (state_sub)
  );

  aes_enc_round u_round (
    .state      (state_q),
    .rkey       (round_key),
    .kind       (upd),
    .next_state (state_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                state_q <= '0;
    else if (load)             state_q <= block_in;
    else if (sub_en)           state_q <= state_sub;
    else if (upd != UPD_NONE)  state_q <= state_upd;
  end

  assign block_out = state_q;

  // R6: the result holds while idle and no start arrives
  a_r6_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable(block_out));

  // R8: a substitution cycle touches only the selected word
  for (genvar i = 0; i < N_WORDS; i++) begin : g_chk
    a_r8_word_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_en && word_idx != WSEL_W'(i))
        |=> $stable(state_q[(N_WORDS-1-i)*WORD_W +: WORD_W]));
  end

endmodule

// File: tb/tb_aes_enc_core.sv
module tb_aes_enc_core;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         long_key = 1'b0;
  logic [127:0] block_in = '0;
  logic [3:0]   round_idx;
  logic [127:0] round_key;
  logic [31:0]  sbox_out;
  logic [31:0]  sbox_in;
  logic [127:0] block_out;
  logic         ready;

  logic [127:0] rk_mem [15];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) p ^= a;
      a = a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
      b = b >> 1;
    end
    return p;
  endfunction

  // S-box from field inverse (x^254) plus affine map
  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] inv = 8'h01;
    logic [7:0] base = x;
    logic [7:0] e = 8'd254;
    logic [7:0] y;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) inv = gmul(inv, base);
      base = gmul(base, base);
    end
    if (x == 8'h00) inv = 8'h00;
    y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
        {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return y;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb(w[31:24]), sb(w[23:16]), sb(w[15:8]), sb(w[7:0])};
  endfunction

  assign round_key = rk_mem[round_idx];
  assign sbox_in   = subw(sbox_out);

  aes_enc_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .long_key  (long_key),
    .round_idx (round_idx),
    .round_key (round_key),
    .sbox_out  (sbox_out),
    .sbox_in   (sbox_in),
    .block_in  (block_in),
    .block_out (block_out),
    .ready     (ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // key schedule computed by the bench; 128-bit keys sit in key[255:128]
  task automatic set_key(input logic [255:0] key, input bit k256);
    int nk = k256 ? 8 : 4;
    int nr = k256 ? 14 : 10;
    logic [31:0] w [60];
    logic [7:0] rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = gmul(rc, 8'h02);
      end else if (nk > 6 && i % nk == 4) begin
        t = subw(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r < 15; r++)
      rk_mem[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : '0;
  endtask

  // byte-array reference cipher; byte i is row i%4 of column i/4
  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input int nr);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk_mem[0][127-8*i -: 8];
    for (int r = 1; r <= nr; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb(s[i]);
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) t[w+4*c] = s[w+4*((c+w)%4)];
      for (int c = 0; c < 4; c++) begin
        if (r != nr) begin
          s[4*c]   = gmul(t[4*c],8'h02)^gmul(t[4*c+1],8'h03)^t[4*c+2]^t[4*c+3];
          s[4*c+1] = t[4*c]^gmul(t[4*c+1],8'h02)^gmul(t[4*c+2],8'h03)^t[4*c+3];
          s[4*c+2] = t[4*c]^t[4*c+1]^gmul(t[4*c+2],8'h02)^gmul(t[4*c+3],8'h03);
          s[4*c+3] = gmul(t[4*c],8'h03)^t[4*c+1]^t[4*c+2]^gmul(t[4*c+3],8'h02);
        end else begin
          for (int w = 0; w < 4; w++) s[4*c+w] = t[4*c+w];
        end
      end
      for (int i = 0; i < 16; i++) s[i] ^= rk_mem[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  // scoreboard queues
  logic [127:0] exp_q [$];
  int due_q [$];
  int nr_q [$];
  logic rdy_prev = 1'b1;
  int maxr = 0;

  // monitor: compares on every rising edge of ready
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready && int'(round_idx) > maxr) maxr = int'(round_idx);
      if (ready && !rdy_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected completion", block_out, '0);
        end else begin
          logic [127:0] e;
          int d, n;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          n = nr_q.pop_front();
          chk(block_out == e, (n == 10) ? "R2" : "R3", "ciphertext", block_out, e);
          chk(cyc == d, "R5", "completion cycle", 128'(cyc), 128'(d));
          chk(maxr == n, "R4", "highest round index", 128'(maxr), 128'(n));
        end
        maxr = 0;
      end
      rdy_prev = ready;
    end
  end

  // driver: start one operation and push its expectation
  task automatic run_op(input logic [127:0] pt, input bit k256,
                        input bit use_known, input logic [127:0] known,
                        input bit chk_words);
    int nr = k256 ? 14 : 10;
    logic [127:0] x;
    while (!ready) @(negedge clk);
    exp_q.push_back(use_known ? known : ref_enc(pt, nr));
    due_q.push_back(cyc + 2 + 5*nr);
    nr_q.push_back(nr);
    block_in = pt;
    long_key = k256;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b0, "R6", "ready after start", 128'(ready), 128'(0));
    if (chk_words) begin
      x = pt ^ rk_mem[0];
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        chk(sbox_out == x[127-32*i -: 32], "R8", "sbox word order",
            128'(sbox_out), 128'(x[127-32*i -: 32]));
        @(negedge clk);
      end
    end
  endtask

  task automatic wait_idle();
    while (!(ready && exp_q.size() == 0)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1", "ready in reset", 128'(ready), 128'(1));
    chk(round_idx == 4'd0, "R1", "round index in reset", 128'(round_idx), 128'(0));
    chk(block_out == '0, "R1", "output in reset", block_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 with the known 128-bit vector, then model-checked blocks
    set_key({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 1'b0);
    run_op(128'h6bc1bee22e409f96e93d7e117393172a, 1'b0, 1'b1,
           128'h3ad77bb40d7a3660a89ecaf32466ef97, 1'b1);
    run_op(128'hae2d8a571e03ac9c9eb76fac45af8e51, 1'b0, 1'b0, '0, 1'b1);
    run_op('0, 1'b0, 1'b0, '0, 1'b0);
    run_op({128{1'b1}}, 1'b0, 1'b0, '0, 1'b0);
    // back-to-back starts (start issued on the cycle ready is seen)
    run_op(128'h00112233445566778899aabbccddeeff, 1'b0, 1'b0, '0, 1'b0);
    run_op(128'h0123456789abcdeffedcba9876543210, 1'b0, 1'b0, '0, 1'b0);
    wait_idle();

    // R6 ready and result hold while idle
    held = block_out;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ready == 1'b1, "R6", "ready held", 128'(ready), 128'(1));
      chk(block_out == held, "R6", "output held", block_out, held);
    end

    // R7 start while busy is ignored
    run_op(128'hdeadbeefcafef00d0badc0de12345678, 1'b0, 1'b0, '0, 1'b0);
    repeat (10) @(negedge clk);
    block_in = 128'hffff0000ffff0000ffff0000ffff0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (100) @(negedge clk);
    chk(ready == 1'b1 && exp_q.size() == 0, "R7", "no second operation",
        128'(ready), 128'(1));

    // R9 key-size change mid-operation has no effect
    run_op(128'h5a5a5a5aa5a5a5a53c3c3c3cc3c3c3c3, 1'b0, 1'b0, '0, 1'b0);
    repeat (3) @(negedge clk);
    long_key = 1'b1;
    wait_idle();
    long_key = 1'b0;

    // R3 with the known 256-bit vector, then a model-checked block
    set_key(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 1'b1);
    run_op(128'h6bc1bee22e409f96e93d7e117393172a, 1'b1, 1'b1,
           128'hf3eed1bdb5d2a03c064b5a7e3db181f8, 1'b1);
    run_op(128'h30c81c46a35ce411e5fbc1191a0a52ef, 1'b1, 1'b0, '0, 1'b0);
    wait_idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule